// File: doc/BRIEF.md
# Program/Erase Status and Suspend Controller

This block is the control and status core of a flash write engine with several planes. A command decoder hands it program, erase, suspend, resume, clear-status and sequence-error requests, each tagged with a target sector. The block checks the sector lock bits and the programming supply, then runs the operation through a cycle counter that stands in for the real program or erase pulse. An erase that fails verify is retried up to a pulse limit. Program fails after its single pulse.

An 8-bit status byte is kept up to date for whichever plane the reader is currently addressing. While an operation runs, bit 0 tells the reader whether the busy plane is the one it addresses or a different one. A suspended operation holds its remaining pulse time and reports ready, with a sticky suspend flag, until it is resumed. Error bits stay set until a clear-status request arrives. A one-cycle done pulse marks the end of every accepted program or erase, whether it passed, failed or was aborted.

Sectors map to planes in contiguous groups: plane = sector / (NUM_SECTORS / NUM_PLANES). Both counts are powers of two, and the defaults are 16 sectors and 4 planes.

Top module: `pe_status_ctrl`

## Requirements
- R1: After reset, status reads 0x80, done is 0 and no plane is marked busy.
- R2: A program request (op code 1) on an unlocked sector with good supply sets status bit 7 to 0 while it runs. After PROG_CYC counted cycles it pulses done for exactly one cycle, and status returns to 0x80.
- R3: An erase request (op code 2) runs pulses of ERASE_CYC cycles each. If verify passes, done comes after one pulse. While the force-fail input holds verify failing, the erase runs MAX_PULSES pulses and then ends with bit 5 set (status 0xA0).
- R4: Supply is sampled when a program or erase is accepted and again at the end of each pulse before verify. If it is low, the operation aborts with a done pulse and bit 3 set (status 0x88).
- R5: A program or erase aimed at a locked sector is aborted at entry with a done pulse. Bit 1 is set and bit 7 stays 1 (status 0x82).
- R6: A sequence-error request (op code 6) sets bits 5, 4, 3 and 1 together (status 0xBA).
- R7: Error bits 5, 4, 3 and 1 stay set until a clear-status request (op code 5). While any of them is set, a new program or erase is ignored: no done, no busy.
- R8: A suspend (op code 3) during an erase halts it. Status then shows bits 7 and 6 (0xC0) until a resume (op code 4), after which the erase finishes the cycles it had left.
- R9: A suspend during a program halts it. Status then shows bits 7 and 2 (0x84) until a resume, after which the program finishes the cycles it had left.
- R10: While an operation is suspended, further program, erase and suspend requests are ignored.
- R11: While busy, status bit 0 is 0 when the addressed plane is the busy one and 1 when another plane is busy. Bit 0 reads 0 when bit 7 is 1.
- R12: A program whose verify fails ends after its one pulse with bit 4 set (status 0x90).
- R13: While an operation runs, the plane-busy vector has exactly the active plane's bit set. Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request strobe, one cycle per request |
| cmd_op | input | 3 | Request code: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear, 6 sequence error |
| cmd_sector | input | SEC_W | Target sector of program or erase |
| vpp_ok | input | 1 | Programming supply good |
| sector_lock | input | NUM_SECTORS | Per-sector write lock |
| force_fail | input | 1 | Test input forcing verify to fail |
| rd_plane | input | PLANE_W | Plane the reader is addressing |
| status_o | output | 8 | Status byte as seen from rd_plane |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| plane_busy_o | output | NUM_PLANES | Per-plane activity, one-hot or zero |

## Verification
Passing program and erase runs are timed to the exact cycle against the parameters. Repeated erase failures then show the retry limit, kept apart from a program failure, which never retries. Supply-low is driven once at entry and once mid-operation, to separate the two sample points from each other and from the lock abort. A suspend of each kind is timed across its halt, which shows that resume continues the remaining count and does not restart it. Requests sent while suspended or while an error is pending confirm that they leave status and done alone. Switching the addressed plane during a run shows which plane bit 0 refers to.

// File: rtl/pe_pkg.sv
package pe_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_CLEAR  = 3'd5,
    OP_SEQERR = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } st_e;

endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer #(
  parameter int PROG_CYC   = 5,
  parameter int ERASE_CYC  = 12,
  parameter int MAX_PULSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  input  logic erase_i,
  output logic tick_o,
  output logic last_o
);
  localparam int LONGEST = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);
  localparam int PULSE_W = $clog2(MAX_PULSES + 1);

  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   limit;
  logic [PULSE_W-1:0] pulse_q;

  assign limit  = erase_i ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
  assign tick_o = run_i && (cnt_q == limit);
  assign last_o = (pulse_q == PULSE_W'(MAX_PULSES - 1));

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else if (run_i) begin
      if (cnt_q == limit) begin
        cnt_q <= '0;
        if (!last_o) pulse_q <= pulse_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !start_i) |=> $stable(cnt_q));

  // R3
  pulse_limit_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_q < PULSE_W'(MAX_PULSES));

endmodule

// File: rtl/pe_plane_view.sv
module pe_plane_view #(
  parameter int NUM_PLANES = 4,
  parameter int PLANE_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               busy_i,
  input  logic [PLANE_W-1:0] act_i,
  input  logic [PLANE_W-1:0] rd_i,
  output logic               other_busy_o,
  output logic [NUM_PLANES-1:0] plane_busy_o
);
  logic [NUM_PLANES-1:0] hot;
  logic [NUM_PLANES-1:0] not_addressed;

  for (genvar i = 0; i < NUM_PLANES; i++) begin : g_plane
    assign hot[i]           = busy_i && (act_i == PLANE_W'(i));
    assign not_addressed[i] = (rd_i != PLANE_W'(i));
  end

  assign other_busy_o = |(hot & not_addressed);

  always_ff @(posedge clk) begin
    if (rst) plane_busy_o <= '0;
    else     plane_busy_o <= hot;
  end

  // R13
  plane_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(plane_busy_o));

endmodule

// File: rtl/pe_status_ctrl.sv
module pe_status_ctrl
  import pe_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int NUM_PLANES  = 4,
  parameter int PROG_CYC    = 5,
  parameter int ERASE_CYC   = 12,
  parameter int MAX_PULSES  = 8,
  localparam int SEC_W      = $clog2(NUM_SECTORS),
  localparam int PLANE_W    = $clog2(NUM_PLANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_op,
  input  logic [SEC_W-1:0]       cmd_sector,
  input  logic                   vpp_ok,
  input  logic [NUM_SECTORS-1:0] sector_lock,
  input  logic                   force_fail,
  input  logic [PLANE_W-1:0]     rd_plane,
  output logic [7:0]             status_o,
  output logic                   done_o,
  output logic [NUM_PLANES-1:0]  plane_busy_o
);
  op_e op;
  st_e st_q;
  logic is_erase_q;
  logic [PLANE_W-1:0] act_q;
  logic esusp_q, psusp_q, es_q, prs_q, vpps_q, sls_q;
  logic err_any, new_req, accept_new, sus_req, res_req;
  logic tick, last_pulse, timer_run, other_busy, busy;
  logic [PLANE_W-1:0] req_plane;

  assign op         = op_e'(cmd_op);
  assign err_any    = es_q | prs_q | vpps_q | sls_q;
  assign new_req    = cmd_valid && (op == OP_PROG || op == OP_ERASE);
  assign accept_new = new_req && (st_q == ST_IDLE) && !err_any;
  assign sus_req    = cmd_valid && (op == OP_SUSP) && (st_q == ST_RUN);
  assign res_req    = cmd_valid && (op == OP_RESUME) && (st_q == ST_SUSP);
  assign timer_run  = (st_q == ST_RUN) && !sus_req;
  assign busy       = (st_q == ST_RUN);
  assign req_plane  = cmd_sector[SEC_W-1 -: PLANE_W];

  pe_op_timer #(
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC),
    .MAX_PULSES(MAX_PULSES)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .start_i(accept_new),
    .run_i  (timer_run),
    .erase_i(is_erase_q),
    .tick_o (tick),
    .last_o (last_pulse)
  );

  pe_plane_view #(
    .NUM_PLANES(NUM_PLANES),
    .PLANE_W   (PLANE_W)
  ) view_i (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy),
    .act_i       (act_q),
    .rd_i        (rd_plane),
    .other_busy_o(other_busy),
    .plane_busy_o(plane_busy_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      is_erase_q <= 1'b0;
      act_q      <= '0;
      esusp_q    <= 1'b0;
      psusp_q    <= 1'b0;
      es_q       <= 1'b0;
      prs_q      <= 1'b0;
      vpps_q     <= 1'b0;
      sls_q      <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (cmd_valid && op == OP_CLEAR) begin
        es_q   <= 1'b0;
        prs_q  <= 1'b0;
        vpps_q <= 1'b0;
        sls_q  <= 1'b0;
      end
      if (cmd_valid && op == OP_SEQERR) begin
        es_q   <= 1'b1;
        prs_q  <= 1'b1;
        vpps_q <= 1'b1;
        sls_q  <= 1'b1;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (accept_new) begin
            is_erase_q <= (op == OP_ERASE);
            act_q      <= req_plane;
            if (sector_lock[cmd_sector]) begin
              sls_q  <= 1'b1;
              done_o <= 1'b1;
            end else if (!vpp_ok) begin
              vpps_q <= 1'b1;
              done_o <= 1'b1;
            end else begin
              st_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (sus_req) begin
            st_q <= ST_SUSP;
            if (is_erase_q) esusp_q <= 1'b1;
            else            psusp_q <= 1'b1;
          end else if (tick) begin
            if (!vpp_ok) begin
              vpps_q <= 1'b1;
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end else if (force_fail) begin
              if (!is_erase_q) begin
                prs_q  <= 1'b1;
                st_q   <= ST_IDLE;
                done_o <= 1'b1;
              end else if (last_pulse) begin
                es_q   <= 1'b1;
                st_q   <= ST_IDLE;
                done_o <= 1'b1;
              end
            end else begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end
          end
        end
        ST_SUSP: begin
          if (res_req) begin
            st_q    <= ST_RUN;
            esusp_q <= 1'b0;
            psusp_q <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= 8'h80;
    else     status_o <= {!busy, esusp_q, es_q, prs_q, vpps_q, psusp_q,
                          sls_q, busy && other_busy};
  end

  // R6
  seq_err_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_SEQERR) |=> (es_q && prs_q && vpps_q && sls_q));

  // R7
  refuse_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    (new_req && err_any && st_q == ST_IDLE) |=> (st_q == ST_IDLE && !done_o));

  // R8
  susp_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUSP) |=> status_o[7]);

  // R10
  single_susp_chk: assert property (@(posedge clk) disable iff (rst)
    !(esusp_q && psusp_q));

  // R10
  susp_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUSP && new_req) |=> (st_q == ST_SUSP && !done_o));

endmodule

// File: tb/pe_status_ctrl_tb.sv
module pe_status_ctrl_tb_top;
  localparam int NS = 16, NP = 4, PC = 5, EC = 12, MP = 8;
  localparam logic [2:0] PROG = 3'd1, ERASE = 3'd2, SUSP = 3'd3,
                         RESUME = 3'd4, CLEAR = 3'd5, SEQERR = 3'd6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [3:0] cmd_sector = '0;
  logic vpp_ok = 1'b1;
  logic [NS-1:0] sector_lock = 16'h0020;
  logic force_fail = 1'b0;
  logic [1:0] rd_plane = '0;
  logic [7:0] status_o;
  logic done_o;
  logic [NP-1:0] plane_busy_o;

  always #5 clk = ~clk;

  pe_status_ctrl #(.NUM_SECTORS(NS), .NUM_PLANES(NP), .PROG_CYC(PC),
                   .ERASE_CYC(EC), .MAX_PULSES(MP)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sector(cmd_sector), .vpp_ok(vpp_ok), .sector_lock(sector_lock),
    .force_fail(force_fail), .rd_plane(rd_plane), .status_o(status_o),
    .done_o(done_o), .plane_busy_o(plane_busy_o));

  typedef struct {
    int    sel;
    string req;
    int    exp;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // sel 0 status, 1 plane-busy vector, 2 done
  task automatic expect_out(int sel, string req, int exp);
    item_t it;
    it.sel = sel; it.req = req; it.exp = exp;
    q.push_back(it);
    ->sample_ev;
  endtask

  initial begin : monitor
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        case (it.sel)
          0:       act = int'(status_o);
          1:       act = int'(plane_busy_o);
          default: act = int'(done_o);
        endcase
        check(it.req, act, it.exp);
      end
    end
  end

  // caller sits at a negedge; the request is taken at the next posedge
  task automatic issue(logic [2:0] op, logic [3:0] sec);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_done(int start, output int cyc);
    cyc = start;
    while (!done_o && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic clear_err(string req);
    issue(CLEAR, 4'd0);
    @(negedge clk);
    expect_out(0, req, 8'h80);
  endtask

  initial begin : driver
    int cyc;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out(0, "R1 status", 8'h80);
    expect_out(1, "R1 plane busy", 0);
    expect_out(2, "R1 done", 0);

    // program, sector 2 in plane 0
    rd_plane = 2'd0;
    issue(PROG, 4'd2);
    @(negedge clk);
    expect_out(0, "R2/R11 busy on own plane", 8'h00);
    expect_out(1, "R13 plane0 busy", 4'b0001);
    rd_plane = 2'd1;
    @(negedge clk);
    expect_out(0, "R11 busy on other plane", 8'h01);
    wait_done(2, cyc);
    check("R2 program cycles", cyc, PC);
    @(negedge clk);
    expect_out(0, "R2 ready after program", 8'h80);
    expect_out(2, "R2 done single cycle", 0);

    // erase pass
    issue(ERASE, 4'd9);
    wait_done(0, cyc);
    check("R3 erase pass cycles", cyc, EC);
    @(negedge clk);
    expect_out(0, "R3 erase pass status", 8'h80);

    // erase fail after all pulses
    force_fail = 1'b1;
    issue(ERASE, 4'd12);
    wait_done(0, cyc);
    check("R3 erase retry cycles", cyc, MP * EC);
    @(negedge clk);
    expect_out(0, "R3 erase fail status", 8'hA0);
    clear_err("R7 clear after erase fail");

    // program fail, then refusal while error pending
    issue(PROG, 4'd0);
    wait_done(0, cyc);
    check("R12 program fail cycles", cyc, PC);
    @(negedge clk);
    expect_out(0, "R12 program fail status", 8'h90);
    force_fail = 1'b0;
    issue(PROG, 4'd1);
    seen = int'(done_o);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      seen = seen | int'(done_o);
    end
    check("R7 refused no done", seen, 0);
    expect_out(0, "R7 error sticky", 8'h90);
    expect_out(1, "R7 refused not busy", 0);
    clear_err("R7 clear after program fail");

    // locked sector 5
    issue(PROG, 4'd5);
    expect_out(2, "R5 lock abort done", 1);
    @(negedge clk);
    expect_out(0, "R5 lock status", 8'h82);
    clear_err("R7 clear after lock");

    // supply low at entry
    vpp_ok = 1'b0;
    issue(ERASE, 4'd3);
    expect_out(2, "R4 entry supply done", 1);
    @(negedge clk);
    expect_out(0, "R4 entry supply status", 8'h88);
    vpp_ok = 1'b1;
    clear_err("R7 clear after supply entry");

    // supply low before verify
    issue(PROG, 4'd2);
    vpp_ok = 1'b0;
    wait_done(0, cyc);
    check("R4 verify supply cycles", cyc, PC);
    @(negedge clk);
    expect_out(0, "R4 verify supply status", 8'h88);
    vpp_ok = 1'b1;
    clear_err("R7 clear after supply verify");

    // sequence error
    issue(SEQERR, 4'd0);
    @(negedge clk);
    expect_out(0, "R6 sequence error status", 8'hBA);
    clear_err("R7 clear after sequence error");

    // erase suspend / resume, sector 8 in plane 2
    rd_plane = 2'd2;
    issue(ERASE, 4'd8);
    repeat (3) @(negedge clk);
    issue(SUSP, 4'd0);
    @(negedge clk);
    expect_out(0, "R8 erase suspended", 8'hC0);
    expect_out(1, "R8 no plane busy when halted", 0);
    issue(PROG, 4'd1);
    issue(SUSP, 4'd0);
    expect_out(2, "R10 no done while suspended", 0);
    @(negedge clk);
    expect_out(0, "R10 requests ignored while suspended", 8'hC0);
    issue(RESUME, 4'd0);
    wait_done(0, cyc);
    check("R8 erase remaining cycles", cyc, EC - 3);
    @(negedge clk);
    expect_out(0, "R8 erase resumed done", 8'h80);

    // program suspend / resume, sector 4 in plane 1
    issue(PROG, 4'd4);
    @(negedge clk);
    expect_out(0, "R11 other plane busy", 8'h01);
    expect_out(1, "R13 plane1 busy", 4'b0010);
    issue(SUSP, 4'd0);
    @(negedge clk);
    expect_out(0, "R9 program suspended", 8'h84);
    issue(RESUME, 4'd0);
    wait_done(0, cyc);
    check("R9 program remaining cycles", cyc, PC - 1);
    @(negedge clk);
    expect_out(0, "R9 program resumed done", 8'h80);

    #1;
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule